// File: doc/BRIEF.md
# Alias-Caching Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Its main store is a pattern table of saturating counters, addressed by the low PC bits just above the instruction alignment. Two branches whose addresses share those bits land on the same counter and damage each other's history. To reduce this, a small fully associative table of counters sits in front of the pattern table and works as a write-back cache. Its tag is the pattern-table index widened by one more PC bit. Two branches that collide closely in time therefore each get their own counter while they both stay resident.

A lookup carries a PC. If the alias table holds that tag, the cached counter predicts and the pattern table is left alone. Otherwise a victim entry is chosen: a free entry first, or else the least recently used one. A valid victim has its counter written back to the pattern table. The victim is then refilled from the pattern table at the new branch's index, and the refilled counter predicts. The prediction is registered and appears with a valid strobe one clock after the lookup. A resolve port carries the PC and real outcome of an executed branch. It adjusts the cached counter when the tag is resident, and the pattern-table counter at the plain index when it is not.

A small state machine records what the previous cycle did. ST_IDLE means no lookup. ST_HIT means a lookup found its tag. ST_FILL means a lookup missed and refilled an entry. Each cycle the next state is chosen from the current lookup alone: no lookup goes to ST_IDLE, a lookup that hits goes to ST_HIT, and a lookup that misses goes to ST_FILL. Any state can move to any other. The prediction outputs are decoded from this state.

Top module: `alias_bpred`

## Requirements
- R1: After reset every alias entry is invalid and every pattern counter holds weakly not-taken (binary 01 for 2-bit counters). The first lookup of any branch predicts not-taken, and pred_valid is low while no lookup has been made.
- R2: pred_valid is high in exactly the cycle after a cycle with lu_valid high, and low otherwise.
- R3: Counters are 2-bit up/down counters that saturate at 00 and 11. A taken outcome increments and a not-taken outcome decrements. The prediction is the counter's most significant bit: 1 means taken.
- R4: A lookup that hits uses the cached counter and leaves the pattern table untouched. A branch with the same index but a different tag bit loads the pattern-table value, not the resident branch's trained counter, and the resident branch keeps its own counter.
- R5: The tag is PC bits [IDX_W+ALIGN : ALIGN], which is bit 8 down to bit 2 by default. PCs that differ only above bit 8 share one alias entry.
- R6: When all entries are valid, a miss evicts the least recently used entry and writes its counter back to the pattern table at the victim's index, where a later refill finds it.
- R7: A miss fills an invalid entry before it evicts any valid entry. Filling an invalid entry writes nothing back.
- R8: A resolve whose tag is not resident updates the pattern-table counter at its plain index, and a later refill of that index sees the update.
- R9: When a miss evicts a victim whose index equals the new branch's index, the refilled counter is the victim's written-back value.
- R10: A resolve and a lookup in the same cycle behave as if the resolve came first. The prediction reflects the outcome just resolved, for a resident tag and for a non-resident one.
- R11: A loop-exit branch that is mostly not taken and an always-taken inner branch share a pattern-table index. After the first pass, every access of the inner branch is predicted taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | Lookup request this cycle |
| lu_pc | input | PC_W | PC of the branch being predicted |
| pred_valid | output | 1 | Registered prediction is valid |
| pred_taken | output | 1 | Registered prediction, 1 = taken |
| rs_valid | input | 1 | Resolve request this cycle |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A lookup and a resolve can land in the same cycle. They can then touch the same counter: either a resident entry, or the pattern-table slot that a refill is about to read. The bench drives both ports on one clock edge for the same branch, once with the tag resident and once without it. It judges the result by checking that the registered prediction already includes the resolved outcome. A second collision inside one cycle is a write-back and a refill at the same pattern index. This is provoked by making a trained branch the least recently used entry and then looking up its aliasing partner, and it is judged by the partner inheriting the trained prediction.

// File: rtl/abp_pkg.sv
package abp_pkg;
    // Kind of operation performed in the previous cycle
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_FILL = 2'd2
    } abp_state_e;
endpackage

// File: rtl/abp_match.sv
// Fully associative tag search over the alias table.
module abp_match #(
    parameter int N     = 16,
    parameter int TAG_W = 7,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [SEL_W-1:0]        sel
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/abp_lru.sv
// Strict LRU ranking (0 = most recent) with victim choice that prefers free entries.
module abp_lru #(
    parameter int N     = 16,
    parameter int SEL_W = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [SEL_W-1:0]        touch_sel,
    input  logic [N-1:0]            valid,
    output logic [SEL_W-1:0]        victim,
    output logic [N-1:0][SEL_W-1:0] rank
);
    localparam logic [SEL_W-1:0] OLDEST = SEL_W'(N - 1);

    logic             any_free;
    logic [SEL_W-1:0] free_sel;
    logic [SEL_W-1:0] old_sel;

    always_comb begin
        any_free = 1'b0;
        free_sel = '0;
        old_sel  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_sel = SEL_W'(i);
            end
            if (rank[i] == OLDEST) begin
                old_sel = SEL_W'(i);
            end
        end
        victim = any_free ? free_sel : old_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                rank[i] <= SEL_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (SEL_W'(i) == touch_sel) begin
                    rank[i] <= '0;
                end else if (rank[i] < rank[touch_sel]) begin
                    rank[i] <= rank[i] + SEL_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/alias_bpred.sv
module alias_bpred
    import abp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int ALIGN = 2,
    parameter int IDX_W = 6,
    parameter int AT_N  = 16,
    parameter int CTR_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lu_valid,
    input  logic [PC_W-1:0] lu_pc,
    output logic            pred_valid,
    output logic            pred_taken,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken
);
    localparam int EXT_W = IDX_W + 1;
    localparam int PT_N  = 1 << IDX_W;
    localparam int SEL_W = $clog2(AT_N);
    localparam logic [CTR_W-1:0] CTR_MAX     = '1;
    localparam logic [CTR_W-1:0] CTR_WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

    function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] c, input logic up);
        if (up) return (c == CTR_MAX) ? c : c + CTR_W'(1);
        else    return (c == '0)      ? c : c - CTR_W'(1);
    endfunction

    // Storage
    logic [CTR_W-1:0]                pt [PT_N];
    logic [AT_N-1:0]                 at_valid;
    logic [AT_N-1:0][EXT_W-1:0]      at_tag;
    logic [AT_N-1:0][CTR_W-1:0]      at_ctr;
    logic [AT_N-1:0][SEL_W-1:0]      lru_rank;

    // Keys
    logic [EXT_W-1:0] lu_key, rs_key;
    logic [IDX_W-1:0] lu_idx, rs_idx;
    assign lu_key = lu_pc[ALIGN +: EXT_W];
    assign rs_key = rs_pc[ALIGN +: EXT_W];
    assign lu_idx = lu_key[IDX_W-1:0];
    assign rs_idx = rs_key[IDX_W-1:0];

    logic             lu_hit, rs_hit;
    logic [SEL_W-1:0] lu_sel, rs_sel, vic;

    abp_match #(.N(AT_N), .TAG_W(EXT_W), .SEL_W(SEL_W)) u_lu_match (
        .valid(at_valid), .tags(at_tag), .key(lu_key), .hit(lu_hit), .sel(lu_sel)
    );
    abp_match #(.N(AT_N), .TAG_W(EXT_W), .SEL_W(SEL_W)) u_rs_match (
        .valid(at_valid), .tags(at_tag), .key(rs_key), .hit(rs_hit), .sel(rs_sel)
    );

    abp_lru #(.N(AT_N), .SEL_W(SEL_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(lu_valid),
        .touch_sel(lu_hit ? lu_sel : vic), .valid(at_valid),
        .victim(vic), .rank(lru_rank)
    );

    // Resolve first: the counter it targets and its new value
    logic [CTR_W-1:0] rs_next;
    assign rs_next = bump(rs_hit ? at_ctr[rs_sel] : pt[rs_idx], rs_taken);

    // Alias counters and pattern slot as seen after this cycle's resolve
    logic [AT_N-1:0][CTR_W-1:0] at_post;
    always_comb begin
        for (int i = 0; i < AT_N; i++) begin
            at_post[i] = (rs_valid && rs_hit && (rs_sel == SEL_W'(i))) ? rs_next : at_ctr[i];
        end
    end

    logic [CTR_W-1:0] pt_at_lu, wb_ctr, fill_ctr, lu_ctr;
    logic [IDX_W-1:0] vic_idx;
    assign pt_at_lu = (rs_valid && !rs_hit && (rs_idx == lu_idx)) ? rs_next : pt[lu_idx];
    assign wb_ctr   = at_post[vic];
    assign vic_idx  = at_tag[vic][IDX_W-1:0];
    // Write-back precedes the refill read at the same index
    assign fill_ctr = (at_valid[vic] && (vic_idx == lu_idx)) ? wb_ctr : pt_at_lu;
    assign lu_ctr   = lu_hit ? at_post[lu_sel] : fill_ctr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            at_valid <= '0;
            at_tag   <= '0;
            at_ctr   <= '0;
            for (int i = 0; i < PT_N; i++) begin
                pt[i] <= CTR_WEAK_NT;
            end
        end else begin
            if (rs_valid) begin
                if (rs_hit) at_ctr[rs_sel] <= rs_next;
                else        pt[rs_idx]     <= rs_next;
            end
            if (lu_valid && !lu_hit) begin
                if (at_valid[vic]) pt[vic_idx] <= wb_ctr;
                at_valid[vic] <= 1'b1;
                at_tag[vic]   <= lu_key;
                at_ctr[vic]   <= fill_ctr;
            end
        end
    end

    // Operation state machine
    abp_state_e state_q, state_d;
    logic       pred_q;

    always_comb begin
        if (!lu_valid)   state_d = ST_IDLE;
        else if (lu_hit) state_d = ST_HIT;
        else             state_d = ST_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        pred_q <= 1'b0;
        else if (lu_valid) pred_q <= lu_ctr[CTR_W-1];
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                pred_valid = 1'b0;
                pred_taken = 1'b0;
            end
            ST_HIT, ST_FILL: begin
                pred_valid = 1'b1;
                pred_taken = pred_q;
            end
            default: begin
                pred_valid = 1'b0;
                pred_taken = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/abp_checker.sv
module abp_checker #(
    parameter int N     = 16,
    parameter int EXT_W = 7,
    parameter int SEL_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lu_valid,
    input logic                    pred_valid,
    input logic [N-1:0]            at_valid,
    input logic [N-1:0][EXT_W-1:0] at_tag,
    input logic [N-1:0][SEL_W-1:0] lru_rank
);
    logic                     dup;
    logic [(1<<SEL_W)-1:0]    seen;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (at_valid[i] && at_valid[j] && (at_tag[i] == at_tag[j])) dup = 1'b1;
            end
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) begin
            seen[lru_rank[i]] = 1'b1;
        end
    end

    AST_PRED_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lu_valid |=> pred_valid);                                       // R2
    AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_valid |=> !pred_valid);                                     // R2
    AST_TAGS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);                                                          // R5
    AST_RANKS_PERMUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N);                                         // R6
    AST_VALID_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_valid & $past(at_valid)) == $past(at_valid));               // R7
    AST_ONE_FILL_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(at_valid) <= $countones($past(at_valid)) + 1);       // R7
endmodule

bind alias_bpred abp_checker #(.N(AT_N), .EXT_W(EXT_W), .SEL_W(SEL_W)) u_abp_checker (
    .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .pred_valid(pred_valid),
    .at_valid(at_valid), .at_tag(at_tag), .lru_rank(lru_rank)
);

// File: tb/alias_bpred_bench.sv
`timescale 1ns/1ps
module alias_bpred_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lu_valid, rs_valid, rs_taken;
    logic [31:0] lu_pc, rs_pc;
    logic        pred_valid, pred_taken;
    int          checks = 0;
    int          fails  = 0;

    always #2 clk = ~clk;

    alias_bpred u_alias_bpred (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_pc(lu_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken)
    );

    // PC built from tag bit, index and upper bits (ALIGN=2, IDX_W=6)
    function automatic logic [31:0] mk(input logic e, input int idx, input int hi);
        logic [5:0]  i6;
        logic [22:0] h23;
        i6  = idx[5:0];
        h23 = hi[22:0];
        return {h23, e, i6, 2'b00};
    endfunction

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lu_valid = 1'b0; rs_valid = 1'b0; rs_taken = 1'b0;
        lu_pc = '0; rs_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] pc, output logic tk);
        @(negedge clk);
        lu_valid = 1'b1; lu_pc = pc;
        @(negedge clk);
        lu_valid = 1'b0;
        tk = pred_taken;
        check_bit("R2", "pred_valid after lookup", pred_valid, 1'b1);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic t);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    task automatic fill_others(input int n);
        logic tk;
        for (int k = 0; k < n; k++) lookup(mk(1'b0, 30 + k, 0), tk);
    endtask

    task automatic t_reset();
        logic tk;
        do_reset();
        check_bit("R1", "pred_valid idle after reset", pred_valid, 1'b0);
        lookup(mk(1'b0, 1, 0), tk);
        check_bit("R1", "first lookup weakly not-taken", tk, 1'b0);
        @(negedge clk);
        check_bit("R2", "pred_valid drops without lookup", pred_valid, 1'b0);
    endtask

    task automatic t_counter();
        logic [31:0] p;
        logic tk;
        do_reset();
        p = mk(1'b0, 2, 0);
        lookup(p, tk);
        resolve(p, 1'b1);                       // 10
        lookup(p, tk); check_bit("R3", "01 plus taken", tk, 1'b1);
        resolve(p, 1'b1); resolve(p, 1'b1);     // 11 saturated
        resolve(p, 1'b0);                       // 10
        lookup(p, tk); check_bit("R3", "saturate high then one NT", tk, 1'b1);
        resolve(p, 1'b0);                       // 01
        lookup(p, tk); check_bit("R3", "down to 01", tk, 1'b0);
        resolve(p, 1'b0); resolve(p, 1'b0); resolve(p, 1'b0); // 00
        resolve(p, 1'b1);                       // 01
        lookup(p, tk); check_bit("R3", "saturate low then one T", tk, 1'b0);
    endtask

    task automatic t_alias();
        logic [31:0] a, b;
        logic tk;
        do_reset();
        a = mk(1'b0, 3, 0); b = mk(1'b1, 3, 0);
        lookup(a, tk); resolve(a, 1'b1); resolve(a, 1'b1);
        lookup(b, tk); check_bit("R4", "partner loads untouched pattern slot", tk, 1'b0);
        resolve(b, 1'b0); resolve(b, 1'b0);
        lookup(a, tk); check_bit("R4", "resident branch keeps own counter", tk, 1'b1);
        lookup(b, tk); check_bit("R4", "partner keeps own counter", tk, 1'b0);
    endtask

    task automatic t_ext();
        logic tk;
        do_reset();
        lookup(mk(1'b0, 4, 0), tk);
        resolve(mk(1'b0, 4, 0), 1'b1);
        lookup(mk(1'b0, 4, 5), tk);
        check_bit("R5", "upper PC bits ignored in tag", tk, 1'b1);
    endtask

    task automatic t_resolve_pt();
        logic tk;
        do_reset();
        resolve(mk(1'b0, 20, 0), 1'b1);
        resolve(mk(1'b0, 20, 0), 1'b1);
        lookup(mk(1'b1, 20, 0), tk);
        check_bit("R8", "refill sees pattern update", tk, 1'b1);
    endtask

    task automatic t_free_first();
        logic [31:0] e0;
        logic tk;
        do_reset();
        e0 = mk(1'b0, 10, 0);
        lookup(e0, tk); resolve(e0, 1'b1); resolve(e0, 1'b1);
        fill_others(14);
        lookup(mk(1'b1, 10, 0), tk);
        check_bit("R7", "free entry used, no write-back", tk, 1'b0);
        lookup(e0, tk);
        check_bit("R7", "trained entry still resident", tk, 1'b1);
    endtask

    task automatic t_evict();
        logic [31:0] e0;
        logic tk;
        do_reset();
        e0 = mk(1'b0, 10, 0);
        lookup(e0, tk); resolve(e0, 1'b1); resolve(e0, 1'b1);
        fill_others(15);
        lookup(mk(1'b0, 50, 0), tk);            // evicts e0 (LRU)
        lookup(mk(1'b1, 10, 0), tk);
        check_bit("R6", "LRU victim counter written back", tk, 1'b1);
        lookup(e0, tk);
        check_bit("R6", "evicted branch refills trained value", tk, 1'b1);
    endtask

    task automatic t_same_index();
        logic [31:0] a;
        logic tk;
        do_reset();
        a = mk(1'b0, 12, 0);
        lookup(a, tk); resolve(a, 1'b1); resolve(a, 1'b1);
        fill_others(15);
        lookup(mk(1'b1, 12, 0), tk);
        check_bit("R9", "refill reads value just written back", tk, 1'b1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] x, y;
        do_reset();
        x = mk(1'b0, 7, 0); y = mk(1'b0, 8, 0);
        begin
            logic tk;
            lookup(x, tk);
        end
        @(negedge clk);
        lu_valid = 1'b1; lu_pc = x; rs_valid = 1'b1; rs_pc = x; rs_taken = 1'b1;
        @(negedge clk);
        lu_valid = 1'b0; rs_valid = 1'b0;
        check_bit("R10", "resident resolve seen by same-cycle lookup", pred_taken, 1'b1);
        @(negedge clk);
        lu_valid = 1'b1; lu_pc = y; rs_valid = 1'b1; rs_pc = y; rs_taken = 1'b1;
        @(negedge clk);
        lu_valid = 1'b0; rs_valid = 1'b0;
        check_bit("R10", "pattern resolve seen by same-cycle refill", pred_taken, 1'b1);
    endtask

    task automatic t_loop_pair();
        logic [31:0] lp, ib;
        logic tk;
        do_reset();
        lp = mk(1'b0, 40, 0); ib = mk(1'b1, 40, 0);
        for (int it = 0; it < 40; it++) begin
            lookup(ib, tk);
            if (it >= 1) check_bit("R11", "inner branch predicted taken", tk, 1'b1);
            resolve(ib, 1'b1);
            lookup(lp, tk);
            resolve(lp, it == 39);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; lu_valid = 1'b0; rs_valid = 1'b0; rs_taken = 1'b0;
        lu_pc = '0; rs_pc = '0;
        t_reset();
        t_counter();
        t_alias();
        t_ext();
        t_resolve_pt();
        t_free_first();
        t_evict();
        t_same_index();
        t_same_cycle();
        t_loop_pair();
        report();
        $finish;
    end
endmodule